// File: doc/BRIEF.md
# Control Channel Bit Serializer

This block drives a single serial control line that runs at the bit rate of the time-division outputs of a time slot switch. It sends 256 bits in every frame. Each bit is the control flag held in one entry of the per-channel connection control memory. External circuits watch this line to prepare switching hardware before the matching channel goes out. To give them that lead, every control bit is sent one whole channel slot before its channel appears on the data outputs.

Within one channel slot, the eight bit cells are shared out across the eight output streams, starting with stream 0. A neighbouring frame counter supplies the position of the current bit cell. The block turns that position into a read address for the control memory. It fetches the flag needed for the next cell during the current cell, and registers it on the cell boundary. The memory and the switching datapath live elsewhere.

Top module: `ctlser_top`

## Requirements
- R1: One bit is sent per clock, with one clock per bit cell. `slot_idx` (0..255) gives the current cell, where `slot_idx[7:3]` is the output channel and `slot_idx[2:0]` is the bit order within the channel (0 = the first cell). Across one full frame, every control entry is sent exactly once.
- R2: The line carries bit 1 of the addressed control entry, high for 1 and low for 0. The other seven bits of the entry have no effect on the line.
- R3: During cell k, `ctl_out` carries the flag of channel ((k>>3)+1) mod 32 on stream k mod 8.
- R4: The flag of stream 0, channel 0 is sent in cell 248, which is channel 31 in its first bit position.
- R5: Cells 0 through 7 carry the channel 1 flags of streams 0 through 7, in that order.
- R6: The memory address is `{stream[2:0], channel[4:0]}`. While `slot_idx` is k, `cmh_addr` points at the entry that belongs to cell k+1, and the fetched bit appears on `ctl_out` from the next clock edge.
- R7: While `rst_n` is low, `ctl_out` is low. Reset takes effect without waiting for a clock edge.
- R8: If `slot_idx` jumps (frame realignment), the cell after the jump carries the flag that belongs to the position one past the previous cell. From then on the output follows the new position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-cell clock, one rising edge per cell |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_idx | input | 8 | Position of the current bit cell within the frame |
| cmh_addr | output | 8 | Read address into the connection control memory |
| cmh_entry | input | 8 | Entry returned for `cmh_addr` in the same cycle |
| ctl_out | output | 1 | Serial control line |

## Verification
The bench goes after the frame wrap. A design that led by one cell instead of one channel, or forgot the modulo on the channel, would put channel 0's flag in the wrong cell or fetch a nonexistent channel 32. It checks the stream-first interleaving within a channel slot, where swapped address fields would scramble the flags across channels. Entries with bit 1 clear and every other bit set catch a design that taps the wrong bit of the entry. A jump in the slot position and a reset in mid-frame expose a design that keeps its own count instead of following its input, or one that leaves the line high during reset.

// File: rtl/ctlser_pkg.sv
package ctlser_pkg;

    // Default geometry: streams per frame equals cells per channel slot
    localparam int unsigned DEF_LANES   = 8;
    localparam int unsigned DEF_CHANS   = 32;
    localparam int unsigned DEF_ENTRY_W = 8;
    localparam int unsigned DEF_CTL_BIT = 1;

    // Registered state of the output stage
    typedef struct packed {
        logic line;
    } ser_state_t;

endpackage

// File: rtl/ctlser_addr.sv
module ctlser_addr #(
    parameter int unsigned LANES = ctlser_pkg::DEF_LANES,
    parameter int unsigned CHANS = ctlser_pkg::DEF_CHANS,
    localparam int unsigned LANE_W = $clog2(LANES),
    localparam int unsigned CHAN_W = $clog2(CHANS),
    localparam int unsigned SLOT_W = LANE_W + CHAN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] slot_i,
    output logic [LANE_W-1:0] lane_o,
    output logic [CHAN_W-1:0] chan_o
);

    localparam logic [SLOT_W-1:0] SLOT_ONE = SLOT_W'(1);
    localparam logic [CHAN_W-1:0] CHAN_ONE = CHAN_W'(1);
    localparam logic [LANE_W-1:0] LANE_ONE = LANE_W'(1);

    logic [SLOT_W-1:0] next_slot;

    // Look one cell ahead, then one channel slot ahead of that cell
    always_comb begin
        next_slot = slot_i + SLOT_ONE;
        lane_o    = next_slot[LANE_W-1:0];
        chan_o    = next_slot[SLOT_W-1:LANE_W] + CHAN_ONE;
    end

    AST_LANE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_i == SLOT_W'($past(slot_i) + SLOT_ONE)) |-> (lane_o == LANE_W'($past(lane_o) + LANE_ONE))); // R5

    AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_i == SLOT_W'($past(slot_i) + SLOT_ONE)) && (lane_o != '0)) |-> $stable(chan_o)); // R5

    AST_CHAN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_i == SLOT_W'($past(slot_i) + SLOT_ONE)) && (lane_o == '0)) |-> (chan_o == CHAN_W'($past(chan_o) + CHAN_ONE))); // R3

endmodule

// File: rtl/ctlser_out.sv
module ctlser_out #(
    parameter int unsigned ENTRY_W = ctlser_pkg::DEF_ENTRY_W,
    parameter int unsigned CTL_BIT = ctlser_pkg::DEF_CTL_BIT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRY_W-1:0] entry_i,
    output logic               line_o
);

    ctlser_pkg::ser_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.line = entry_i[CTL_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_o = st_q.line;

    AST_LINE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (line_o == $past(entry_i[CTL_BIT]))); // R2

endmodule

// File: rtl/ctlser_top.sv
module ctlser_top #(
    parameter int unsigned LANES   = ctlser_pkg::DEF_LANES,
    parameter int unsigned CHANS   = ctlser_pkg::DEF_CHANS,
    parameter int unsigned ENTRY_W = ctlser_pkg::DEF_ENTRY_W,
    parameter int unsigned CTL_BIT = ctlser_pkg::DEF_CTL_BIT,
    localparam int unsigned LANE_W = $clog2(LANES),
    localparam int unsigned CHAN_W = $clog2(CHANS),
    localparam int unsigned SLOT_W = LANE_W + CHAN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SLOT_W-1:0]  slot_idx,
    output logic [SLOT_W-1:0]  cmh_addr,
    input  logic [ENTRY_W-1:0] cmh_entry,
    output logic               ctl_out
);

    logic [LANE_W-1:0] lane;
    logic [CHAN_W-1:0] chan;

    ctlser_addr #(.LANES(LANES), .CHANS(CHANS)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .slot_i (slot_idx),
        .lane_o (lane),
        .chan_o (chan)
    );

    // Stream field high, channel field low
    assign cmh_addr = {lane, chan};

    ctlser_out #(.ENTRY_W(ENTRY_W), .CTL_BIT(CTL_BIT)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .entry_i (cmh_entry),
        .line_o  (ctl_out)
    );

    AST_ADDR_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx[LANE_W-1:0] == '0) |-> (cmh_addr[SLOT_W-1:CHAN_W] == LANE_W'(1))); // R6

endmodule

// File: tb/sim_ctlser_top.sv
module sim_ctlser_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] slot_idx = 8'd0;
    logic [7:0] cmh_addr;
    logic [7:0] cmh_entry;
    logic       ctl_out;
    logic [7:0] mem [0:255];

    int tests = 0;
    int fails = 0;
    int prev_slot = 0;
    int ones = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign cmh_entry = mem[cmh_addr];

    ctlser_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_idx  (slot_idx),
        .cmh_addr  (cmh_addr),
        .cmh_entry (cmh_entry),
        .ctl_out   (ctl_out)
    );

    function automatic int entry_of(int k);
        int ch;
        int st;
        ch = ((k / 8) + 1) % 32;
        st = k % 8;
        return st * 32 + ch;
    endfunction

    task automatic check(int got, int exp, string req);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at t=%0t", req, got, exp, $time);
        end
    endtask

    task automatic fill(int mode);
        for (int a = 0; a < 256; a++) begin
            case (mode)
                0: mem[a] = 8'h00;
                1: mem[a] = 8'h02;
                2: mem[a] = 8'hFD;
                default: mem[a] = 8'((a * 37 + 11) ^ (((a * 7 + 3) >> 2) & 1 ? 8'h02 : 8'h00));
            endcase
        end
    endtask

    task automatic run_slots(int start, int count, string first_tag);
        ones = 0;
        for (int i = 0; i < count; i++) begin
            int k;
            int nxt;
            string tag;
            k = (start + i) % 256;
            @(negedge clk);
            nxt = (prev_slot + 1) % 256;
            if (i == 0 && first_tag != "") tag = first_tag;
            else if (nxt == 248) tag = "R4";
            else if (nxt < 8) tag = "R5";
            else tag = "R3";
            check(int'(ctl_out), int'(mem[entry_of(nxt)][1]), tag);
            if (ctl_out) ones++;
            slot_idx = 8'(k);
            #1;
            check(int'(cmh_addr), entry_of((k + 1) % 256), "R6");
            prev_slot = k;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got hang expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int pop;
        fill(1);
        repeat (3) @(negedge clk);
        check(int'(ctl_out), 0, "R7");
        fill(0);
        rst_n = 1'b1;
        prev_slot = 0;

        // all clear, then all set in the control bit only
        run_slots(1, 255, "");
        run_slots(0, 256, "");
        check(ones, 0, "R1");
        fill(1);
        run_slots(0, 256, "");
        check(ones, 256, "R1");

        // other bits set, control bit clear: line stays low
        fill(2);
        run_slots(0, 256, "R2");
        check(ones, 0, "R2");

        // mixed pattern over two frames
        fill(3);
        pop = 0;
        for (int a = 0; a < 256; a++) pop += int'(mem[a][1]);
        run_slots(0, 256, "");
        check(ones, pop, "R1");
        run_slots(0, 256, "");
        check(ones, pop, "R1");

        // a single entry set: appears exactly once per frame
        for (int w = 0; w < 4; w++) begin
            int e;
            e = (w == 0) ? 0 : (w == 1) ? 1 : (w == 2) ? 255 : 3 * 32 + 17;
            fill(0);
            mem[e] = 8'h02;
            run_slots(0, 256, "");
            check(ones, 1, "R1");
        end

        // realignment jump
        fill(3);
        run_slots(0, 40, "");
        run_slots(100, 30, "R8");
        run_slots(250, 20, "R8");

        // mid-frame reset
        fill(1);
        run_slots(10, 5, "");
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(int'(ctl_out), 0, "R7");
        repeat (2) @(negedge clk);
        check(int'(ctl_out), 0, "R7");
        slot_idx = 8'd200;
        prev_slot = 200;
        rst_n = 1'b1;
        run_slots(201, 100, "");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule